// File: doc/BRIEF.md
# Packed-Ring Descriptor Fetch Planner

This block sits on the device side of a packed descriptor ring and decides how many ring entries the descriptor fetcher may request from host memory in a single batch. It keeps the device's own ring position and lap bit. It also keeps the most recent driver position it has learned. The driver position is a ring offset paired with a lap (wrap) bit. From the two positions the block derives how many descriptors are available. It then offers one contiguous read request at a time, covering as many valid entries as the burst limit and the ring end allow. It never offers an entry the driver has not yet published.

The driver position arrives by two routes. The first is a doorbell write that carries an offset and a wrap bit. The second is a read of the driver-written offset/wrap field. That field sits next to the event-suppression words, so one 8-byte-aligned read returns both. Once the backlog is deep, the block turns doorbells off, which spares the host CPU its costly register writes. While doorbells are off, it polls the driver field whenever it is about to run dry. It turns doorbells back on only when a poll shows nothing new past its own position. Either route can update the count in any cycle, and updates that do not move the count forward are dropped.

Top module: `ring_fetch_planner`

## Requirements
- R1: After reset the device position and the known driver position are both offset 0 with lap bit 1, so the ring is empty: req_valid is 0, req_start is 0, req_wrap is 1, db_enable is 1 and poll_req_valid is 0.
- R2: The available count is derived from the driver position (offset, lap) and the device position. With equal lap bits it is driver offset minus device offset. With different lap bits it is driver offset plus RING_SIZE minus device offset. Equal offsets therefore mean empty for equal laps and full (RING_SIZE) for different laps.
- R3: req_count equals the smallest of three values: the available count, MAX_BURST, and the number of entries from req_start to the ring end. req_valid is 1 exactly when the available count is nonzero.
- R4: When req_valid and req_ready are both 1 at a clock edge, the device offset advances by req_count. If it reaches RING_SIZE it becomes 0 and req_wrap toggles. The new position is visible on req_start/req_wrap after that edge.
- R5: A doorbell or poll response whose position would not raise the available count above its current value leaves the known driver position unchanged. This covers positions that are equal, behind, or more than one ring ahead.
- R6: When a doorbell and an accepted poll response arrive in the same cycle, the one giving the larger available count is kept, and the doorbell wins a tie. A position update in the same cycle as an accepted request is measured against the device position before that request.
- R7: If doorbells are enabled and the available count exceeds DB_OFF_THRESH, db_enable falls at the next clock edge.
- R8: With doorbells off, no poll outstanding and the available count at most POLL_LOW, poll_req_valid rises one cycle later. It stays high until poll_req_ready is seen, and no new poll is raised until the response to that poll returns.
- R9: A response to the outstanding poll re-enables doorbells only if it shows no descriptor past the device position, the available count is 0, and no doorbell advances the count in that cycle. A response that advances the count leaves doorbells off.
- R10: A poll response that arrives while no poll has been accepted is ignored.
- R11: No request ever covers an entry beyond the available count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| db_valid | input | 1 | Doorbell carrying notification data |
| db_off | input | OFF_W | Driver offset from the doorbell |
| db_wrap | input | 1 | Driver lap bit from the doorbell |
| db_enable | output | 1 | 1 when the driver should ring doorbells |
| poll_req_valid | output | 1 | Request to read the driver offset/wrap field |
| poll_req_ready | input | 1 | Poll read request accepted |
| poll_rsp_valid | input | 1 | Poll read data returned |
| poll_rsp_off | input | OFF_W | Driver offset returned by the poll |
| poll_rsp_wrap | input | 1 | Driver lap bit returned by the poll |
| req_valid | output | 1 | A descriptor batch read is offered |
| req_ready | input | 1 | Batch read accepted |
| req_start | output | OFF_W | First ring entry of the batch |
| req_wrap | output | 1 | Device lap bit for the batch entries |
| req_count | output | $clog2(MAX_BURST+1) | Number of contiguous entries in the batch |

## Verification
Two functions can fall in the same cycle: a doorbell and the response to an outstanding poll can both offer a new driver position. Either of those can also coincide with an accepted batch request that moves the device position. The bench provokes the first collision by holding a poll outstanding and driving a doorbell and the response on the same edge. It does this once with the doorbell ahead and once with the response ahead. It provokes the second by ringing a doorbell while a batch is accepted. Each outcome is judged by the start and length of the next offered batch, which exposes which position was kept and what base it was measured against.

// File: rtl/rfp_pkg.sv
package rfp_pkg;

  typedef enum logic [1:0] {
    POLL_IDLE = 2'd0,
    POLL_ASK  = 2'd1,
    POLL_WAIT = 2'd2
  } poll_state_e;

  // Entries between a device position and a driver position, or -1 when
  // the driver position cannot be a forward position of the ring.
  function automatic int ring_distance(input int drv_pos, input logic drv_lap,
                                       input int dev_pos, input logic dev_lap,
                                       input int ring);
    int d;
    if (drv_pos >= ring || dev_pos >= ring) return -1;
    if (drv_lap == dev_lap) d = drv_pos - dev_pos;
    else                    d = drv_pos + ring - dev_pos;
    if (d < 0 || d > ring) return -1;
    return d;
  endfunction

endpackage

// File: rtl/rfp_fill_track.sv
module rfp_fill_track
  import rfp_pkg::*;
#(
  parameter int OFF_W     = 15,
  parameter int RING_SIZE = 256,
  localparam int CNT_W    = $clog2(RING_SIZE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             db_valid,
  input  logic [OFF_W-1:0] db_off,
  input  logic             db_wrap,
  input  logic             rsp_take,
  input  logic [OFF_W-1:0] rsp_off,
  input  logic             rsp_wrap,
  input  logic [OFF_W-1:0] dev_off,
  input  logic             dev_wrap,
  output logic [CNT_W-1:0] avail,
  output logic             db_adv,
  output logic             rsp_noadv
);

  logic [OFF_W-1:0] drv_off_q, drv_off_d;
  logic             drv_wrap_q, drv_wrap_d;
  logic             drv_en;
  int               cur_i, db_i, rs_i;

  // next-state: pick the candidate with the larger forward distance
  always_comb begin
    cur_i = ring_distance(int'(drv_off_q), drv_wrap_q, int'(dev_off), dev_wrap, RING_SIZE);
    if (cur_i < 0) cur_i = 0;
    db_i = db_valid ? ring_distance(int'(db_off), db_wrap, int'(dev_off), dev_wrap, RING_SIZE) : -1;
    rs_i = rsp_take ? ring_distance(int'(rsp_off), rsp_wrap, int'(dev_off), dev_wrap, RING_SIZE) : -1;
    drv_off_d  = drv_off_q;
    drv_wrap_d = drv_wrap_q;
    drv_en     = 1'b0;
    if (db_i >= rs_i) begin
      if (db_i > cur_i) begin
        drv_en     = 1'b1;
        drv_off_d  = db_off;
        drv_wrap_d = db_wrap;
      end
    end else if (rs_i > cur_i) begin
      drv_en     = 1'b1;
      drv_off_d  = rsp_off;
      drv_wrap_d = rsp_wrap;
    end
    avail     = CNT_W'(cur_i);
    db_adv    = db_valid && (db_i > cur_i);
    rsp_noadv = rsp_take && (rs_i <= 0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_off_q  <= '0;
      drv_wrap_q <= 1'b1;
    end else if (drv_en) begin
      drv_off_q  <= drv_off_d;
      drv_wrap_q <= drv_wrap_d;
    end
  end

endmodule

// File: rtl/rfp_burst_gen.sv
module rfp_burst_gen #(
  parameter int OFF_W     = 15,
  parameter int RING_SIZE = 256,
  parameter int MAX_BURST = 8,
  localparam int CNT_W    = $clog2(RING_SIZE + 1),
  localparam int BURST_W  = $clog2(MAX_BURST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   avail,
  input  logic               req_ready,
  output logic               req_valid,
  output logic [OFF_W-1:0]   req_start,
  output logic               req_wrap,
  output logic [BURST_W-1:0] req_count
);

  logic [OFF_W-1:0] dev_off_q, dev_off_d;
  logic             dev_wrap_q, dev_wrap_d;
  logic             step_en;
  int               to_end, n, s;

  // next-state: batch size and the position after it
  always_comb begin
    to_end = RING_SIZE - int'(dev_off_q);
    n      = int'(avail);
    if (n > MAX_BURST) n = MAX_BURST;
    if (n > to_end)    n = to_end;
    req_valid  = (n > 0);
    req_count  = BURST_W'(n);
    step_en    = req_valid && req_ready;
    s          = int'(dev_off_q) + n;
    dev_off_d  = dev_off_q;
    dev_wrap_d = dev_wrap_q;
    if (s >= RING_SIZE) begin
      dev_off_d  = '0;
      dev_wrap_d = ~dev_wrap_q;
    end else begin
      dev_off_d  = OFF_W'(s);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_off_q  <= '0;
      dev_wrap_q <= 1'b1;
    end else if (step_en) begin
      dev_off_q  <= dev_off_d;
      dev_wrap_q <= dev_wrap_d;
    end
  end

  assign req_start = dev_off_q;
  assign req_wrap  = dev_wrap_q;

endmodule

// File: rtl/rfp_notify_ctl.sv
module rfp_notify_ctl
  import rfp_pkg::*;
#(
  parameter int RING_SIZE     = 256,
  parameter int DB_OFF_THRESH = 32,
  parameter int POLL_LOW      = 8,
  localparam int CNT_W        = $clog2(RING_SIZE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] avail,
  input  logic             db_adv,
  input  logic             rsp_valid,
  input  logic             rsp_noadv,
  input  logic             poll_req_ready,
  output logic             db_enable,
  output logic             poll_req_valid,
  output logic             rsp_take
);

  poll_state_e st_q, st_d;
  logic        db_en_q, db_en_d, db_en_upd;
  logic        reenable;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      POLL_IDLE: if (!db_en_q && int'(avail) <= POLL_LOW) st_d = POLL_ASK;
      POLL_ASK:  if (poll_req_ready)                      st_d = POLL_WAIT;
      POLL_WAIT: if (rsp_valid)                           st_d = POLL_IDLE;
      default:                                            st_d = POLL_IDLE;
    endcase
  end

  always_comb begin
    rsp_take  = rsp_valid && (st_q == POLL_WAIT);
    reenable  = rsp_take && rsp_noadv && (int'(avail) == 0) && !db_adv;
    db_en_d   = db_en_q;
    db_en_upd = 1'b0;
    if (db_en_q && int'(avail) > DB_OFF_THRESH) begin
      db_en_d   = 1'b0;
      db_en_upd = 1'b1;
    end else if (!db_en_q && reenable) begin
      db_en_d   = 1'b1;
      db_en_upd = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= POLL_IDLE;
      db_en_q <= 1'b1;
    end else begin
      st_q <= st_d;
      if (db_en_upd) db_en_q <= db_en_d;
    end
  end

  assign db_enable      = db_en_q;
  assign poll_req_valid = (st_q == POLL_ASK);

endmodule

// File: rtl/ring_fetch_planner.sv
module ring_fetch_planner #(
  parameter int OFF_W         = 15,
  parameter int RING_SIZE     = 256,
  parameter int MAX_BURST     = 8,
  parameter int DB_OFF_THRESH = 32,
  parameter int POLL_LOW      = 8,
  localparam int CNT_W        = $clog2(RING_SIZE + 1),
  localparam int BURST_W      = $clog2(MAX_BURST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               db_valid,
  input  logic [OFF_W-1:0]   db_off,
  input  logic               db_wrap,
  output logic               db_enable,
  output logic               poll_req_valid,
  input  logic               poll_req_ready,
  input  logic               poll_rsp_valid,
  input  logic [OFF_W-1:0]   poll_rsp_off,
  input  logic               poll_rsp_wrap,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [OFF_W-1:0]   req_start,
  output logic               req_wrap,
  output logic [BURST_W-1:0] req_count
);

  logic [CNT_W-1:0] avail_cur;
  logic             db_adv;
  logic             rsp_noadv;
  logic             rsp_take;

  rfp_fill_track #(
    .OFF_W     (OFF_W),
    .RING_SIZE (RING_SIZE)
  ) fill_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .db_valid  (db_valid),
    .db_off    (db_off),
    .db_wrap   (db_wrap),
    .rsp_take  (rsp_take),
    .rsp_off   (poll_rsp_off),
    .rsp_wrap  (poll_rsp_wrap),
    .dev_off   (req_start),
    .dev_wrap  (req_wrap),
    .avail     (avail_cur),
    .db_adv    (db_adv),
    .rsp_noadv (rsp_noadv)
  );

  rfp_burst_gen #(
    .OFF_W     (OFF_W),
    .RING_SIZE (RING_SIZE),
    .MAX_BURST (MAX_BURST)
  ) burst_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .avail     (avail_cur),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .req_start (req_start),
    .req_wrap  (req_wrap),
    .req_count (req_count)
  );

  rfp_notify_ctl #(
    .RING_SIZE     (RING_SIZE),
    .DB_OFF_THRESH (DB_OFF_THRESH),
    .POLL_LOW      (POLL_LOW)
  ) notify_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .avail          (avail_cur),
    .db_adv         (db_adv),
    .rsp_valid      (poll_rsp_valid),
    .rsp_noadv      (rsp_noadv),
    .poll_req_ready (poll_req_ready),
    .db_enable      (db_enable),
    .poll_req_valid (poll_req_valid),
    .rsp_take       (rsp_take)
  );

endmodule

// File: rtl/ring_fetch_planner_chk.sv
module ring_fetch_planner_chk #(
  parameter int OFF_W         = 15,
  parameter int RING_SIZE     = 256,
  parameter int MAX_BURST     = 8,
  parameter int DB_OFF_THRESH = 32,
  localparam int CNT_W        = $clog2(RING_SIZE + 1),
  localparam int BURST_W      = $clog2(MAX_BURST + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               db_enable,
  input logic               poll_req_valid,
  input logic               poll_req_ready,
  input logic               poll_rsp_valid,
  input logic               req_valid,
  input logic               req_ready,
  input logic [OFF_W-1:0]   req_start,
  input logic               req_wrap,
  input logic [BURST_W-1:0] req_count,
  input logic [CNT_W-1:0]   avail
);

  logic poll_out_q;
  logic fire;

  assign fire = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               poll_out_q <= 1'b0;
    else if (poll_req_valid && poll_req_ready) poll_out_q <= 1'b1;
    else if (poll_rsp_valid)                   poll_out_q <= 1'b0;
  end

  p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(req_count) != 0 && int'(req_count) <= MAX_BURST &&
                   int'(req_start) + int'(req_count) <= RING_SIZE));

  p_within_avail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> int'(req_count) <= int'(avail));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && int'(req_start) + int'(req_count) < RING_SIZE) |=>
      (int'(req_start) == int'($past(req_start)) + int'($past(req_count)) &&
       req_wrap == $past(req_wrap)));

  p_lap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && int'(req_start) + int'(req_count) == RING_SIZE) |=>
      (int'(req_start) == 0 && req_wrap != $past(req_wrap)));

  p_db_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (db_enable && int'(avail) > DB_OFF_THRESH) |=> !db_enable);

  p_reen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(db_enable) |-> $past(poll_rsp_valid));

  p_one_poll_r8: assert property (@(posedge clk) disable iff (!rst_n)
    poll_out_q |-> !poll_req_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_req_valid && !poll_req_ready) |=> poll_req_valid);

endmodule

bind ring_fetch_planner ring_fetch_planner_chk #(
  .OFF_W         (OFF_W),
  .RING_SIZE     (RING_SIZE),
  .MAX_BURST     (MAX_BURST),
  .DB_OFF_THRESH (DB_OFF_THRESH)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .db_enable      (db_enable),
  .poll_req_valid (poll_req_valid),
  .poll_req_ready (poll_req_ready),
  .poll_rsp_valid (poll_rsp_valid),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_start      (req_start),
  .req_wrap       (req_wrap),
  .req_count      (req_count),
  .avail          (avail_cur)
);

// File: tb/ring_fetch_planner_tb_top.sv
module ring_fetch_planner_tb_top;

  localparam int OFF_W   = 15;
  localparam int RING    = 16;
  localparam int BURST   = 4;
  localparam int BURST_W = $clog2(BURST + 1);

  logic               clk = 1'b0;
  logic               rst_n;
  logic               db_valid, db_wrap;
  logic [OFF_W-1:0]   db_off;
  logic               db_enable;
  logic               poll_req_valid, poll_req_ready;
  logic               poll_rsp_valid, poll_rsp_wrap;
  logic [OFF_W-1:0]   poll_rsp_off;
  logic               req_valid, req_ready, req_wrap;
  logic [OFF_W-1:0]   req_start;
  logic [BURST_W-1:0] req_count;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  ring_fetch_planner #(
    .OFF_W(OFF_W), .RING_SIZE(RING), .MAX_BURST(BURST),
    .DB_OFF_THRESH(6), .POLL_LOW(1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .db_valid(db_valid), .db_off(db_off), .db_wrap(db_wrap),
    .db_enable(db_enable),
    .poll_req_valid(poll_req_valid), .poll_req_ready(poll_req_ready),
    .poll_rsp_valid(poll_rsp_valid), .poll_rsp_off(poll_rsp_off),
    .poll_rsp_wrap(poll_rsp_wrap),
    .req_valid(req_valid), .req_ready(req_ready), .req_start(req_start),
    .req_wrap(req_wrap), .req_count(req_count)
  );

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic chk_req(input string tag, input int s, input int c, input int w);
    chk({tag, " req_valid"}, int'(req_valid), 1);
    chk({tag, " req_start"}, int'(req_start), s);
    chk({tag, " req_count"}, int'(req_count), c);
    chk({tag, " req_wrap"},  int'(req_wrap),  w);
  endtask

  task automatic ring_db(input int off, input int w);
    db_valid = 1'b1; db_off = OFF_W'(off); db_wrap = w[0];
    @(negedge clk);
    db_valid = 1'b0;
  endtask

  task automatic poll_reply(input int off, input int w);
    poll_rsp_valid = 1'b1; poll_rsp_off = OFF_W'(off); poll_rsp_wrap = w[0];
    @(negedge clk);
    poll_rsp_valid = 1'b0;
  endtask

  task automatic consume(input string tag, input int s, input int c, input int w);
    chk_req(tag, s, c, w);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic poll_issue();
    chk("R8 poll raised", int'(poll_req_valid), 1);
    @(negedge clk);
    chk("R8 poll held", int'(poll_req_valid), 1);
    poll_req_ready = 1'b1;
    @(negedge clk);
    poll_req_ready = 1'b0;
    chk("R8 single poll outstanding", int'(poll_req_valid), 0);
  endtask

  task automatic t_reset();
    chk("R1 req_valid", int'(req_valid), 0);
    chk("R1 req_start", int'(req_start), 0);
    chk("R1 req_wrap", int'(req_wrap), 1);
    chk("R1 db_enable", int'(db_enable), 1);
    chk("R1 poll_req_valid", int'(poll_req_valid), 0);
  endtask

  task automatic t_first_batch();
    ring_db(3, 1);
    chk("R7 below threshold keeps doorbells", int'(db_enable), 1);
    consume("R11 batch limited to available", 0, 3, 1);
    chk("R4 ring drained", int'(req_valid), 0);
    chk("R4 start advanced", int'(req_start), 3);
  endtask

  task automatic t_stale();
    ring_db(2, 1);
    chk("R5 behind position ignored", int'(req_valid), 0);
    ring_db(3, 1);
    chk("R5 equal position ignored", int'(req_valid), 0);
    chk("R5 device start unchanged", int'(req_start), 3);
  endtask

  task automatic t_threshold();
    ring_db(13, 1);
    chk("R7 doorbells still on one cycle", int'(db_enable), 1);
    chk_req("R3 burst cap", 3, 4, 1);
    @(negedge clk);
    chk("R7 doorbells off", int'(db_enable), 0);
    consume("R3 burst cap", 3, 4, 1);
    consume("R3 burst cap", 7, 4, 1);
    consume("R11 tail limited to available", 11, 2, 1);
    chk("R11 nothing left", int'(req_valid), 0);
    @(negedge clk);
  endtask

  task automatic t_poll_no_advance();
    poll_issue();
    poll_reply(13, 1);
    chk("R9 empty poll re-enables doorbells", int'(db_enable), 1);
    chk("R9 no new batch", int'(req_valid), 0);
    chk("R8 no poll with doorbells on", int'(poll_req_valid), 0);
  endtask

  task automatic t_wrap_and_poll_advance();
    ring_db(5, 0);
    chk_req("R2 lap-crossing count, R3 end cap", 13, 3, 1);
    consume("R3 end cap", 13, 3, 1);
    chk("R7 doorbells off again", int'(db_enable), 0);
    consume("R4 lap toggled at ring end", 0, 4, 0);
    chk_req("R3 small remainder", 4, 1, 0);
    @(negedge clk);
    poll_issue();
    poll_reply(10, 0);
    chk_req("R9 advancing poll used", 4, 4, 0);
    chk("R9 doorbells stay off", int'(db_enable), 0);
    chk("R8 poll cleared", int'(poll_req_valid), 0);
  endtask

  task automatic t_unsolicited();
    poll_reply(12, 0);
    consume("R10 before stray response", 4, 4, 0);
    chk_req("R10 stray response ignored", 8, 2, 0);
  endtask

  task automatic t_collisions();
    consume("R6 drain", 8, 2, 0);
    @(negedge clk);
    poll_issue();
    db_valid = 1'b1; db_off = OFF_W'(12); db_wrap = 1'b0;
    poll_rsp_valid = 1'b1; poll_rsp_off = OFF_W'(14); poll_rsp_wrap = 1'b0;
    @(negedge clk);
    db_valid = 1'b0; poll_rsp_valid = 1'b0;
    chk_req("R6 response ahead of doorbell wins", 10, 4, 0);
    consume("R6 drain", 10, 4, 0);
    @(negedge clk);
    poll_issue();
    db_valid = 1'b1; db_off = OFF_W'(2); db_wrap = 1'b1;
    poll_rsp_valid = 1'b1; poll_rsp_off = OFF_W'(0); poll_rsp_wrap = 1'b1;
    @(negedge clk);
    db_valid = 1'b0; poll_rsp_valid = 1'b0;
    chk_req("R6 doorbell ahead of response wins", 14, 2, 0);
    consume("R4 end of ring", 14, 2, 0);
    chk_req("R4 lap back to 1", 0, 2, 1);
    db_valid = 1'b1; db_off = OFF_W'(6); db_wrap = 1'b1;
    req_ready = 1'b1;
    @(negedge clk);
    db_valid = 1'b0; req_ready = 1'b0;
    chk_req("R6 doorbell during accepted batch", 2, 4, 1);
  endtask

  task automatic t_full_ring();
    consume("R2 drain", 2, 4, 1);
    @(negedge clk);
    poll_issue();
    poll_reply(6, 0);
    chk_req("R2 equal offsets other lap is full", 6, 4, 1);
    consume("R2 full ring", 6, 4, 1);
    consume("R2 full ring", 10, 4, 1);
    consume("R2 full ring end cap", 14, 2, 1);
    chk_req("R2 six left of full ring", 0, 4, 0);
    chk("R7 doorbells remain off", int'(db_enable), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog all requirements act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    db_valid = 1'b0; db_off = '0; db_wrap = 1'b0;
    poll_req_ready = 1'b0; poll_rsp_valid = 1'b0;
    poll_rsp_off = '0; poll_rsp_wrap = 1'b0;
    req_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_batch();
    t_stale();
    t_threshold();
    t_poll_no_advance();
    t_wrap_and_poll_advance();
    t_unsolicited();
    t_collisions();
    t_full_ring();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule